// File: doc/BRIEF.md
# Instruction Field Decoder and Target Generator

This block is purely combinational. It takes one 32-bit instruction word and the 64-bit next-PC value, and splits the word into the fields of five instruction layouts: immediate, jump, register, big-immediate and floating-point. Every field is driven on its own output at all times, whatever the layout. A three-bit layout selector drives a mask of field-valid flags, so a downstream stage knows which of the extracted fields mean something for the current instruction.

From the 12-bit immediate field the block derives three values: a 64-bit sign-extended immediate, a six-bit shift amount for full-width shifts and a five-bit shift amount for word shifts. It also computes two control-transfer addresses. The branch address is the next-PC plus the sign-extended immediate scaled by two. The jump address keeps the next-PC bits above bit 27 and places the 27-bit target, scaled by two, below them. The block does not read register files, map opcodes to operations or sequence the PC.

Top module: `insn_field_decoder`

## Requirements
- R1: `opcode_o` equals instruction bits [31:25] and `jop_o` equals bits [31:27].
- R2: `ra_o` equals bits [24:20], `rb_o` equals bits [19:15] and `rt_o` equals bits [24:20].
- R3: `rc_o` equals bits [4:0] and `rd_o` equals bits [9:5].
- R4: `funct_o` equals bits [14:12], `functr_o` equals bits [11:5] and `ffunct_o` equals bits [14:10].
- R5: `imm_o` equals bits [11:0], `bigimm_o` equals bits [19:0] and `target_o` equals bits [26:0].
- R6: `simm_o` is bits [11:0] sign-extended to 64 bits, so bit 11 is copied into bits [63:12].
- R7: `shamt_o` equals bits [5:0] and `shamtw_o` equals bits [4:0].
- R8: `br_tgt_o` equals next-PC plus the sign-extended immediate shifted left by one, modulo 2^64.
- R9: `jmp_tgt_o` equals next-PC with bits [27:0] cleared, plus the target field shifted left by one. Bits [63:28] therefore always equal next-PC bits [63:28], and bit 0 is always zero.
- R10: `fld_vld_o` flag bits are numbered as follows: bit 0 opcode, 1 jump opcode, 2 ra, 3 rb, 4 rc, 5 rd, 6 rt, 7 funct, 8 functr, 9 ffunct, 10 imm, 11 bigimm, 12 target. The selector encodings set these bits:
  - 0 (immediate): bits {0,2,3,7,10}
  - 1 (jump): bits {1,12}
  - 2 (register): bits {0,2,3,4,7,8}
  - 3 (big-immediate): bits {0,6,11}
  - 4 (floating-point): bits {0,2,3,4,5,9}
  - 5 to 7: no bits.
- R11: All outputs settle from the inputs alone, with no clock and no stored state. Changing an input between clock edges changes the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmt_sel | input | 3 | Layout selector for the valid mask |
| insn_word | input | 32 | Instruction word |
| npc | input | 64 | Next-PC value |
| opcode_o | output | 7 | Main opcode |
| jop_o | output | 5 | Jump opcode |
| ra_o | output | 5 | First source specifier |
| rb_o | output | 5 | Second source specifier |
| rc_o | output | 5 | Third specifier (destination or operand) |
| rd_o | output | 5 | Fourth specifier (floating-point layout) |
| rt_o | output | 5 | Big-immediate destination specifier |
| funct_o | output | 3 | Short function code |
| functr_o | output | 7 | Register-layout function code |
| ffunct_o | output | 5 | Floating-point function code |
| imm_o | output | 12 | Raw immediate |
| bigimm_o | output | 20 | Raw big immediate |
| target_o | output | 27 | Raw jump target |
| simm_o | output | 64 | Sign-extended immediate |
| shamt_o | output | 6 | Full-width shift amount |
| shamtw_o | output | 5 | Word shift amount |
| br_tgt_o | output | 64 | Branch address |
| jmp_tgt_o | output | 64 | Jump address |
| fld_vld_o | output | 13 | Field-valid flags for the selected layout |

## Verification
The hardest cases to reach are carries at the edges of the address adders. One is a branch sum that wraps past 2^64. Another is a negative offset that borrows through every upper bit of the next-PC. A third is a jump whose next-PC has all of bits [27:0] set, so any leak of those bits into the result would show. Uniform random words and PCs almost never produce these cases. The stimulus therefore pairs random instruction words with directed next-PC values near zero, near the top of the address space and with the low 28 bits saturated. It also forces the immediate to its extreme values 0x7FF and 0x800, and steps the selector through all eight codes.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSN_W   = 32;
    localparam int XLEN     = 64;
    localparam int OPC_W    = 7;
    localparam int JOPC_W   = 5;
    localparam int REG_W    = 5;
    localparam int IMM_W    = 12;
    localparam int TGT_W    = 27;
    localparam int BIGIMM_W = 20;
    localparam int FUNCT_W  = 3;
    localparam int FUNCTR_W = 7;
    localparam int FFUNCT_W = 5;
    localparam int SHAMT_W  = 6;
    localparam int SHAMTW_W = 5;
    localparam int BR_SHIFT = 1;
    localparam int J_SHIFT  = 1;
    localparam int J_REGION = TGT_W + J_SHIFT;
    localparam int FMT_W    = 3;
    localparam int NFLD     = 13;

    typedef enum logic [FMT_W-1:0] {
        FMT_IMM = 3'd0,
        FMT_JMP = 3'd1,
        FMT_REG = 3'd2,
        FMT_BIG = 3'd3,
        FMT_FLT = 3'd4
    } fmt_e;

    // packed structs list the most significant field first
    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [REG_W-1:0]   ra;
        logic [REG_W-1:0]   rb;
        logic [FUNCT_W-1:0] funct;
        logic [IMM_W-1:0]   imm;
    } lay_imm_t;

    typedef struct packed {
        logic [JOPC_W-1:0] jop;
        logic [TGT_W-1:0]  target;
    } lay_jmp_t;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [REG_W-1:0]    ra;
        logic [REG_W-1:0]    rb;
        logic [FUNCT_W-1:0]  funct;
        logic [FUNCTR_W-1:0] functr;
        logic [REG_W-1:0]    rc;
    } lay_reg_t;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [REG_W-1:0]    rt;
        logic [BIGIMM_W-1:0] bigimm;
    } lay_big_t;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [REG_W-1:0]    ra;
        logic [REG_W-1:0]    rb;
        logic [FFUNCT_W-1:0] ffunct;
        logic [REG_W-1:0]    rd;
        logic [REG_W-1:0]    rc;
    } lay_flt_t;

    typedef union packed {
        lay_imm_t i;
        lay_jmp_t j;
        lay_reg_t r;
        lay_big_t b;
        lay_flt_t f;
    } insn_u;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [JOPC_W-1:0]   jop;
        logic [REG_W-1:0]    ra;
        logic [REG_W-1:0]    rb;
        logic [REG_W-1:0]    rc;
        logic [REG_W-1:0]    rd;
        logic [REG_W-1:0]    rt;
        logic [FUNCT_W-1:0]  funct;
        logic [FUNCTR_W-1:0] functr;
        logic [FFUNCT_W-1:0] ffunct;
        logic [IMM_W-1:0]    imm;
        logic [BIGIMM_W-1:0] bigimm;
        logic [TGT_W-1:0]    target;
    } fields_t;

    // declared in reverse so that opcode lands on bit 0
    typedef struct packed {
        logic target;
        logic bigimm;
        logic imm;
        logic ffunct;
        logic functr;
        logic funct;
        logic rt;
        logic rd;
        logic rc;
        logic rb;
        logic ra;
        logic jop;
        logic opcode;
    } fld_vld_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/idec_split.sv
module idec_split
    import idec_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           flds
);
    insn_u word;

    assign word = insn_u'(insn);

    always_comb begin
        flds.opcode = word.i.opcode;
        flds.jop    = word.j.jop;
        flds.ra     = word.r.ra;
        flds.rb     = word.f.rb;
        flds.rc     = word.r.rc;
        flds.rd     = word.f.rd;
        flds.rt     = word.b.rt;
        flds.funct  = word.i.funct;
        flds.functr = word.r.functr;
        flds.ffunct = word.f.ffunct;
        flds.imm    = word.i.imm;
        flds.bigimm = word.b.bigimm;
        flds.target = word.j.target;
    end
endmodule

// File: rtl/idec_imm.sv
module idec_imm
    import idec_pkg::*;
(
    input  logic [IMM_W-1:0]    imm,
    output logic [XLEN-1:0]     simm,
    output logic [SHAMT_W-1:0]  shamt,
    output logic [SHAMTW_W-1:0] shamtw
);
    assign simm   = sext_imm(imm);
    assign shamt  = imm[SHAMT_W-1:0];
    assign shamtw = imm[SHAMTW_W-1:0];

    // R6: everything above the immediate sign bit repeats it
    always_comb begin
        a_r6_sign_fill: assert (simm[XLEN-1:IMM_W-1] == '0 || simm[XLEN-1:IMM_W-1] == '1)
            else $error("R6 sign fill broken");
    end
endmodule

// File: rtl/idec_tgt.sv
module idec_tgt
    import idec_pkg::*;
(
    input  logic [XLEN-1:0]  npc,
    input  logic [XLEN-1:0]  simm,
    input  logic [TGT_W-1:0] target,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    localparam logic [XLEN-1:0] REGION_MASK = {XLEN{1'b1}} << J_REGION;

    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] j_off;

    assign br_off  = simm << BR_SHIFT;
    assign j_off   = {{(XLEN-TGT_W){1'b0}}, target} << J_SHIFT;
    assign br_tgt  = npc + br_off;
    assign jmp_tgt = (npc & REGION_MASK) + j_off;

    always_comb begin
        // R9: upper region is kept from the next-PC
        a_r9_region_kept: assert (jmp_tgt[XLEN-1:J_REGION] == npc[XLEN-1:J_REGION])
            else $error("R9 jump region changed");
        // R9: scaled target leaves bit 0 clear
        a_r9_align: assert (jmp_tgt[0] == 1'b0)
            else $error("R9 jump misaligned");
        // R8: even offset keeps next-PC parity
        a_r8_parity: assert (br_tgt[0] == npc[0])
            else $error("R8 branch parity");
    end
endmodule

// File: rtl/idec_vld.sv
module idec_vld
    import idec_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output fld_vld_t         vld
);
    always_comb begin
        vld = '0;
        case (fmt)
            FMT_IMM: begin
                vld.opcode = 1'b1; vld.ra = 1'b1; vld.rb = 1'b1;
                vld.funct = 1'b1; vld.imm = 1'b1;
            end
            FMT_JMP: begin
                vld.jop = 1'b1; vld.target = 1'b1;
            end
            FMT_REG: begin
                vld.opcode = 1'b1; vld.ra = 1'b1; vld.rb = 1'b1;
                vld.rc = 1'b1; vld.funct = 1'b1; vld.functr = 1'b1;
            end
            FMT_BIG: begin
                vld.opcode = 1'b1; vld.rt = 1'b1; vld.bigimm = 1'b1;
            end
            FMT_FLT: begin
                vld.opcode = 1'b1; vld.ra = 1'b1; vld.rb = 1'b1;
                vld.rc = 1'b1; vld.rd = 1'b1; vld.ffunct = 1'b1;
            end
            default: vld = '0;
        endcase
    end

    always_comb begin
        // R10: main and jump opcodes never both valid
        a_r10_opc_excl: assert (!(vld.opcode && vld.jop))
            else $error("R10 opcode overlap");
        // R10: rt only in a layout without ra
        a_r10_rt_excl: assert (!(vld.rt && vld.ra))
            else $error("R10 rt/ra overlap");
    end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
    import idec_pkg::*;
(
    input  logic [FMT_W-1:0]    fmt_sel,
    input  logic [INSN_W-1:0]   insn_word,
    input  logic [XLEN-1:0]     npc,
    output logic [OPC_W-1:0]    opcode_o,
    output logic [JOPC_W-1:0]   jop_o,
    output logic [REG_W-1:0]    ra_o,
    output logic [REG_W-1:0]    rb_o,
    output logic [REG_W-1:0]    rc_o,
    output logic [REG_W-1:0]    rd_o,
    output logic [REG_W-1:0]    rt_o,
    output logic [FUNCT_W-1:0]  funct_o,
    output logic [FUNCTR_W-1:0] functr_o,
    output logic [FFUNCT_W-1:0] ffunct_o,
    output logic [IMM_W-1:0]    imm_o,
    output logic [BIGIMM_W-1:0] bigimm_o,
    output logic [TGT_W-1:0]    target_o,
    output logic [XLEN-1:0]     simm_o,
    output logic [SHAMT_W-1:0]  shamt_o,
    output logic [SHAMTW_W-1:0] shamtw_o,
    output logic [XLEN-1:0]     br_tgt_o,
    output logic [XLEN-1:0]     jmp_tgt_o,
    output logic [NFLD-1:0]     fld_vld_o
);
    fields_t  flds;
    fld_vld_t vld;

    idec_split u_split (.insn(insn_word), .flds(flds));

    idec_imm u_imm (
        .imm   (flds.imm),
        .simm  (simm_o),
        .shamt (shamt_o),
        .shamtw(shamtw_o)
    );

    idec_tgt u_tgt (
        .npc    (npc),
        .simm   (simm_o),
        .target (flds.target),
        .br_tgt (br_tgt_o),
        .jmp_tgt(jmp_tgt_o)
    );

    idec_vld u_vld (.fmt(fmt_sel), .vld(vld));

    assign opcode_o  = flds.opcode;
    assign jop_o     = flds.jop;
    assign ra_o      = flds.ra;
    assign rb_o      = flds.rb;
    assign rc_o      = flds.rc;
    assign rd_o      = flds.rd;
    assign rt_o      = flds.rt;
    assign funct_o   = flds.funct;
    assign functr_o  = flds.functr;
    assign ffunct_o  = flds.ffunct;
    assign imm_o     = flds.imm;
    assign bigimm_o  = flds.bigimm;
    assign target_o  = flds.target;
    assign fld_vld_o = vld;

    always_comb begin
        // R7: word shift amount nests inside the full one
        a_r7_shamt_nest: assert (shamtw_o == shamt_o[SHAMTW_W-1:0])
            else $error("R7 shift amounts disagree");
        // R2: rt and ra share one slot
        a_r2_rt_ra: assert (rt_o == ra_o)
            else $error("R2 rt/ra slot mismatch");
        // R1: jump opcode is the top of the main opcode
        a_r1_jop_top: assert (jop_o == opcode_o[OPC_W-1:OPC_W-JOPC_W])
            else $error("R1 opcode slices disagree");
    end
endmodule

// File: tb/sim_insn_field_decoder.sv
`timescale 1ns/1ps
module sim_insn_field_decoder;

    logic        clk = 1'b0;
    logic [2:0]  fmt_sel;
    logic [31:0] insn_word;
    logic [63:0] npc;
    logic [6:0]  opcode_o;
    logic [4:0]  jop_o, ra_o, rb_o, rc_o, rd_o, rt_o, ffunct_o, shamtw_o;
    logic [2:0]  funct_o;
    logic [6:0]  functr_o;
    logic [11:0] imm_o;
    logic [19:0] bigimm_o;
    logic [26:0] target_o;
    logic [63:0] simm_o, br_tgt_o, jmp_tgt_o;
    logic [5:0]  shamt_o;
    logic [12:0] fld_vld_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    insn_field_decoder u0 (
        .fmt_sel(fmt_sel), .insn_word(insn_word), .npc(npc),
        .opcode_o(opcode_o), .jop_o(jop_o), .ra_o(ra_o), .rb_o(rb_o),
        .rc_o(rc_o), .rd_o(rd_o), .rt_o(rt_o), .funct_o(funct_o),
        .functr_o(functr_o), .ffunct_o(ffunct_o), .imm_o(imm_o),
        .bigimm_o(bigimm_o), .target_o(target_o), .simm_o(simm_o),
        .shamt_o(shamt_o), .shamtw_o(shamtw_o), .br_tgt_o(br_tgt_o),
        .jmp_tgt_o(jmp_tgt_o), .fld_vld_o(fld_vld_o)
    );

    function automatic logic [63:0] exp_simm(input logic [31:0] w);
        logic [63:0] s;
        s = {52'd0, w[11:0]};
        if (w[11]) s = s | 64'hFFFF_FFFF_FFFF_F000;
        return s;
    endfunction

    function automatic logic [63:0] exp_br(input logic [31:0] w, input logic [63:0] pc);
        return pc + (exp_simm(w) * 64'd2);
    endfunction

    function automatic logic [63:0] exp_jmp(input logic [31:0] w, input logic [63:0] pc);
        logic [63:0] base;
        base = pc - (pc % 64'h1000_0000);
        return base + ({37'd0, w[26:0]} * 64'd2);
    endfunction

    function automatic logic [12:0] exp_mask(input logic [2:0] f);
        logic [12:0] m;
        m = '0;
        case (f)
            3'd0: begin m[0]=1; m[2]=1; m[3]=1; m[7]=1; m[10]=1; end
            3'd1: begin m[1]=1; m[12]=1; end
            3'd2: begin m[0]=1; m[2]=1; m[3]=1; m[4]=1; m[7]=1; m[8]=1; end
            3'd3: begin m[0]=1; m[6]=1; m[11]=1; end
            3'd4: begin m[0]=1; m[2]=1; m[3]=1; m[4]=1; m[5]=1; m[9]=1; end
            default: m = '0;
        endcase
        return m;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (insn=%h npc=%h fmt=%0d)",
                     req, got, exp, insn_word, npc, fmt_sel);
        end
    endtask

    task automatic check_all();
        logic [31:0] w;
        w = insn_word;
        chk("R1 opcode", 64'(opcode_o), 64'(w[31:25]));
        chk("R1 jop",    64'(jop_o),    64'(w[31:27]));
        chk("R2 ra",     64'(ra_o),     64'(w[24:20]));
        chk("R2 rb",     64'(rb_o),     64'(w[19:15]));
        chk("R2 rt",     64'(rt_o),     64'(w[24:20]));
        chk("R3 rc",     64'(rc_o),     64'(w[4:0]));
        chk("R3 rd",     64'(rd_o),     64'(w[9:5]));
        chk("R4 funct",  64'(funct_o),  64'(w[14:12]));
        chk("R4 functr", 64'(functr_o), 64'(w[11:5]));
        chk("R4 ffunct", 64'(ffunct_o), 64'(w[14:10]));
        chk("R5 imm",    64'(imm_o),    64'(w[11:0]));
        chk("R5 bigimm", 64'(bigimm_o), 64'(w[19:0]));
        chk("R5 target", 64'(target_o), 64'(w[26:0]));
        chk("R6 simm",   simm_o,        exp_simm(w));
        chk("R7 shamt",  64'(shamt_o),  64'(w[5:0]));
        chk("R7 shamtw", 64'(shamtw_o), 64'(w[4:0]));
        chk("R8 branch", br_tgt_o,      exp_br(w, npc));
        chk("R9 jump",   jmp_tgt_o,     exp_jmp(w, npc));
        chk("R10 mask",  64'(fld_vld_o), 64'(exp_mask(fmt_sel)));
    endtask

    task automatic apply(input logic [2:0] f, input logic [31:0] w, input logic [63:0] pc);
        @(posedge clk);
        fmt_sel   = f;
        insn_word = w;
        npc       = pc;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        fmt_sel = '0; insn_word = '0; npc = '0;
        void'($urandom(32'd1234));
        // all-zero inputs
        @(negedge clk);
        check_all();
        // R6/R8 extremes of the immediate
        apply(3'd0, 32'h0000_07FF, 64'h0000_0000_0000_1000);
        apply(3'd0, 32'h0000_0800, 64'h0000_0000_0000_0000);   // borrow through all bits
        apply(3'd0, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001);
        apply(3'd0, 32'h0000_07FF, 64'hFFFF_FFFF_FFFF_FFFE);   // R8 wrap past 2^64
        // R9 saturated low bits and maximum target
        apply(3'd1, 32'hFFFF_FFFF, 64'h1234_5678_0FFF_FFFF);
        apply(3'd1, 32'h07FF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(3'd1, 32'hF800_0000, 64'h0000_0000_1FFF_FFFF);
        // R10 every selector code
        for (int f = 0; f < 8; f++)
            apply(3'(f), $urandom, {$urandom, $urandom});
        // R11: input change between edges, no clock edge needed
        @(posedge clk);
        #1 insn_word = 32'hA5A5_5A5A; npc = 64'h0000_0000_0FFF_FFF0; fmt_sel = 3'd2;
        #1 check_all();
        #0.5 insn_word = 32'h5A5A_A5A5;
        #0.5 check_all();
        // random sweep with corner-biased PCs
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] pc;
            case ($urandom % 5)
                0: pc = {$urandom, $urandom};
                1: pc = 64'hFFFF_FFFF_FFFF_F000 | 64'($urandom % 4096);
                2: pc = 64'($urandom % 4096);
                3: pc = {$urandom, 4'h0, 28'hFFF_FFFF} | {32'd0, $urandom} & 64'hFFFF_FFFF_F000_0000;
                default: pc = {$urandom, $urandom};
            endcase
            apply(3'($urandom % 8), $urandom, pc);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule